// File: doc/BRIEF.md
# Escape-Prefixed Opcode Class Decoder

This block sits at the front of an 8-bit accumulator processor and sorts each incoming instruction byte into an operation class. On each cycle, one byte can be offered with a valid strobe. The block registers an enumerated operation code, a stack-relative flag and an invalid-instruction flag, and holds them for one cycle. The primary table is organised by rows on the upper nibble. Some of its rows contain irregular cells that do not follow the rest of the row. One reserved escape byte (0x9E) makes no result of its own. Instead, it arms a pending state, and the next accepted byte is decoded from a smaller second table whose operations address memory relative to the stack pointer.

A small sequencer runs before any decoding. After reset it supplies the reset values of the programmer-visible registers. It then fetches the 16-bit start address from the two vector bytes at 0xFFFE (high byte) and 0xFFFF (low byte), one byte per acknowledged request. Bytes are accepted only after both vector bytes have arrived.

The sequencer has five states:
- SQ_RESET: a single cycle after reset.
- SQ_VEC_HI: request the byte at 0xFFFE.
- SQ_VEC_LO: request the byte at 0xFFFF.
- SQ_RUN: decode from the primary table.
- SQ_ESC: the prefix is pending, so decode from the stack-relative table.

The transitions are:
- T_BOOT: SQ_RESET to SQ_VEC_HI, always.
- T_HI_DONE: SQ_VEC_HI to SQ_VEC_LO, on vector acknowledge.
- T_LO_DONE: SQ_VEC_LO to SQ_RUN, on vector acknowledge.
- T_ESCAPE: SQ_RUN to SQ_ESC, when the escape byte is accepted.
- T_SECOND: SQ_ESC to SQ_RUN, when any byte is accepted.

Reset returns to SQ_RESET from any state.

Top module: `prefixed_op_decoder`

## Requirements
- R1: While reset is held, the outputs take these values: reg_sp=0x00FF, reg_a=0x00, reg_hx=0x0000 and reg_ccr=0x60. reg_ccr packs the flags as V,1,1,H,I,N,Z,C from bit 7 down to bit 0. In addition, op_vld=0, bad_op=0, stk_rel=0, pfx_pend=0 and ready=0.
- R2: After reset, vec_req rises with vec_addr=0xFFFE. The data acknowledged there becomes start_pc[15:8]. The next request has vec_addr=0xFFFF, and its data becomes start_pc[7:0]. ready rises in the cycle after the second acknowledge, and vec_req falls at the same time.
- R3: A byte offered while ready=0 is ignored, and op_vld stays 0 after it.
- R4: In the primary table, rows 0x0, 0x1 and 0x2 decode to OP_BITBR, OP_BITSC and OP_BCC respectively. In rows 0x3 to 0x7 the low nibble selects a read-modify-write class: 0 NEG, 1 CBEQ, 3 COM, 4 LSR, 6 ROR, 7 ASR, 8 LSL, 9 ROL, A DEC, B DBNZ, C INC, D TST, F CLR.
- R5: Rows 0x3 to 0x7 have irregular cells:
  - Low nibble 2: 0x42 MUL, 0x52 DIV, 0x62 NSA, 0x72 DAA, and 0x32 invalid.
  - Low nibble 5: 0x35 STHX, 0x45 and 0x55 LDHX, 0x65 and 0x75 CPHX.
  - Low nibble E: MOV for 0x4E to 0x7E, and 0x3E invalid.
- R6: In rows 0xA to 0xF the low nibble selects the ALU or load/store class, 0 to F: SUB, CMP, SBC, CPX, AND, BIT, LDA, STA, EOR, ADC, ORA, ADD, JMP, JSR, LDX, STX. Four cells in row 0xA override this: 0xA7 is AIS, 0xAC is invalid, 0xAD is BSR and 0xAF is AIX.
- R7: Rows 0x8 and 0x9 decode as follows; every other code in these rows is invalid.

  | Row | Low nibble | Class |
  |---|---|---|
  | 0x8 | 0 | RTI |
  | 0x8 | 1 | RTS |
  | 0x8 | 3 | SWI |
  | 0x8 | 4, 5 | XFER |
  | 0x8 | 6 to B | STKMOV |
  | 0x8 | C | CLRH |
  | 0x8 | E | STOP |
  | 0x8 | F | WAIT |
  | 0x9 | 0 to 3 | BCC |
  | 0x9 | 4, 5, 7, F | XFER |
  | 0x9 | 8 to B | FLAG |
  | 0x9 | C | RSP |
  | 0x9 | D | NOP |

- R8: Accepting 0x9E in SQ_RUN produces no result: op_vld=0 in the following cycle, and pfx_pend=1 from the following cycle onward. pfx_pend returns to 0 in the cycle after the next accepted byte.
- R9: The escaped table decodes these second bytes:
  - Row 0x6: the read-modify-write set of R4, except that low nibbles 2, 5 and E are invalid.
  - Rows 0xD and 0xE: the ALU set of R6 without the row-0xA overrides, except that low nibble C is invalid.
  - Every other second byte is invalid.

  A valid escaped result carries stk_rel=1. Primary results always carry stk_rel=0.
- R10: An invalid byte produces, for exactly one cycle, op_vld=1, bad_op=1, op_code=OP_NONE and stk_rel=0.
- R11: A reset while the prefix is pending discards it. After the vector fetch, the next byte is decoded from the primary table.
- R12: Each accepted non-escape byte yields an op_vld pulse of exactly one cycle, registered in the cycle after acceptance. op_vld is 0 in any cycle that follows a cycle without an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Instruction byte strobe |
| byte_in | input | 8 | Instruction byte |
| vec_ack | input | 1 | Vector byte returned this cycle |
| vec_data | input | 8 | Returned vector byte |
| vec_req | output | 1 | Vector byte request |
| vec_addr | output | 16 | Address of requested vector byte |
| start_pc | output | 16 | Assembled start address |
| ready | output | 1 | Bytes are being accepted |
| pfx_pend | output | 1 | Escape prefix pending |
| op_vld | output | 1 | Decode result valid |
| op_code | output | 6 | Operation class (op_e encoding) |
| stk_rel | output | 1 | Stack-relative addressing |
| bad_op | output | 1 | Invalid instruction |
| reg_sp | output | 16 | Reset value of stack pointer |
| reg_a | output | 8 | Reset value of accumulator |
| reg_hx | output | 16 | Reset value of index pair H:X |
| reg_ccr | output | 8 | Reset value of condition flags |

## Verification
A state machine left in SQ_ESC after its second byte appears at the ports in two ways. pfx_pend stays high, and the very next byte comes back with stk_rel set or is flagged invalid one cycle after it is accepted. The near-exhaustive sweeps expose this within a single byte, because every primary code and every escaped code is compared against an independent table. A vector sequence stuck or out of order shows up on vec_addr in the cycle after the first acknowledge. A late or early ready shows up as a missing or extra op_vld one cycle after a byte is offered.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;
    localparam int OP_W   = 6;

    typedef enum logic [OP_W-1:0] {
        OP_NONE, OP_BITBR, OP_BITSC, OP_BCC,
        OP_NEG, OP_CBEQ, OP_COM, OP_LSR, OP_ROR, OP_ASR, OP_LSL, OP_ROL,
        OP_DEC, OP_DBNZ, OP_INC, OP_TST, OP_CLR,
        OP_MUL, OP_DIV, OP_NSA, OP_DAA, OP_STHX, OP_LDHX, OP_CPHX, OP_MOV,
        OP_SUB, OP_CMP, OP_SBC, OP_CPX, OP_AND, OP_BIT, OP_LDA, OP_STA,
        OP_EOR, OP_ADC, OP_ORA, OP_ADD, OP_JMP, OP_JSR, OP_LDX, OP_STX,
        OP_AIS, OP_BSR, OP_AIX,
        OP_RTI, OP_RTS, OP_SWI, OP_XFER, OP_STKMOV, OP_CLRH, OP_STOP, OP_WAIT,
        OP_FLAG, OP_RSP, OP_NOP
    } op_e;

    typedef enum logic [2:0] {
        SQ_RESET, SQ_VEC_HI, SQ_VEC_LO, SQ_RUN, SQ_ESC
    } sq_e;

    // Read-modify-write column map shared by both tables
    function automatic op_e rmw_of(input logic [3:0] lo);
        op_e r;
        case (lo)
            4'h0:    r = OP_NEG;
            4'h1:    r = OP_CBEQ;
            4'h3:    r = OP_COM;
            4'h4:    r = OP_LSR;
            4'h6:    r = OP_ROR;
            4'h7:    r = OP_ASR;
            4'h8:    r = OP_LSL;
            4'h9:    r = OP_ROL;
            4'hA:    r = OP_DEC;
            4'hB:    r = OP_DBNZ;
            4'hC:    r = OP_INC;
            4'hD:    r = OP_TST;
            4'hF:    r = OP_CLR;
            default: r = OP_NONE;
        endcase
        return r;
    endfunction

    // ALU / load-store column map shared by both tables
    function automatic op_e alu_of(input logic [3:0] lo);
        op_e r;
        case (lo)
            4'h0:    r = OP_SUB;
            4'h1:    r = OP_CMP;
            4'h2:    r = OP_SBC;
            4'h3:    r = OP_CPX;
            4'h4:    r = OP_AND;
            4'h5:    r = OP_BIT;
            4'h6:    r = OP_LDA;
            4'h7:    r = OP_STA;
            4'h8:    r = OP_EOR;
            4'h9:    r = OP_ADC;
            4'hA:    r = OP_ORA;
            4'hB:    r = OP_ADD;
            4'hC:    r = OP_JMP;
            4'hD:    r = OP_JSR;
            4'hE:    r = OP_LDX;
            default: r = OP_STX;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/opdec_primary.sv
module opdec_primary
    import opdec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ESC_BYTE = 8'h9E
) (
    input  logic [BYTE_W-1:0] code,
    output op_e               op,
    output logic              inval,
    output logic              esc
);

    logic [3:0] hi;
    logic [3:0] lo;

    assign hi  = code[7:4];
    assign lo  = code[3:0];
    assign esc = (code == ESC_BYTE);

    always_comb begin
        op = OP_NONE;
        unique case (hi)
            4'h0: op = OP_BITBR;
            4'h1: op = OP_BITSC;
            4'h2: op = OP_BCC;
            4'h3, 4'h4, 4'h5, 4'h6, 4'h7: begin
                case (lo)
                    4'h2: begin
                        case (hi)
                            4'h4:    op = OP_MUL;
                            4'h5:    op = OP_DIV;
                            4'h6:    op = OP_NSA;
                            4'h7:    op = OP_DAA;
                            default: op = OP_NONE;
                        endcase
                    end
                    4'h5: begin
                        case (hi)
                            4'h3:       op = OP_STHX;
                            4'h4, 4'h5: op = OP_LDHX;
                            default:    op = OP_CPHX;
                        endcase
                    end
                    4'hE:    op = (hi == 4'h3) ? OP_NONE : OP_MOV;
                    default: op = rmw_of(lo);
                endcase
            end
            4'h8: begin
                case (lo)
                    4'h0:                      op = OP_RTI;
                    4'h1:                      op = OP_RTS;
                    4'h3:                      op = OP_SWI;
                    4'h4, 4'h5:                op = OP_XFER;
                    4'h6, 4'h7, 4'h8, 4'h9,
                    4'hA, 4'hB:                op = OP_STKMOV;
                    4'hC:                      op = OP_CLRH;
                    4'hE:                      op = OP_STOP;
                    4'hF:                      op = OP_WAIT;
                    default:                   op = OP_NONE;
                endcase
            end
            4'h9: begin
                case (lo)
                    4'h0, 4'h1, 4'h2, 4'h3:    op = OP_BCC;
                    4'h4, 4'h5, 4'h7, 4'hF:    op = OP_XFER;
                    4'h8, 4'h9, 4'hA, 4'hB:    op = OP_FLAG;
                    4'hC:                      op = OP_RSP;
                    4'hD:                      op = OP_NOP;
                    default:                   op = OP_NONE;
                endcase
            end
            default: begin
                op = alu_of(lo);
                if (hi == 4'hA) begin
                    case (lo)
                        4'h7:    op = OP_AIS;
                        4'hC:    op = OP_NONE;
                        4'hD:    op = OP_BSR;
                        4'hF:    op = OP_AIX;
                        default: op = alu_of(lo);
                    endcase
                end
            end
        endcase
    end

    assign inval = (op == OP_NONE) && !esc;

endmodule

// File: rtl/opdec_stack.sv
module opdec_stack
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] code,
    output op_e               op,
    output logic              inval
);

    logic [3:0] hi;
    logic [3:0] lo;

    assign hi = code[7:4];
    assign lo = code[3:0];

    always_comb begin
        op = OP_NONE;
        unique case (hi)
            4'h6: begin
                case (lo)
                    4'h2, 4'h5, 4'hE: op = OP_NONE;
                    default:          op = rmw_of(lo);
                endcase
            end
            4'hD, 4'hE: begin
                op = (lo == 4'hC) ? OP_NONE : alu_of(lo);
            end
            default: op = OP_NONE;
        endcase
    end

    assign inval = (op == OP_NONE);

endmodule

// File: rtl/opdec_seq.sv
module opdec_seq
    import opdec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE  = 16'hFFFE,
    parameter logic [ADDR_W-1:0] RESET_SP  = 16'h00FF,
    parameter logic [BYTE_W-1:0] RESET_CCR = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              is_esc,
    input  logic              vec_ack,
    input  logic [BYTE_W-1:0] vec_data,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [ADDR_W-1:0] start_pc,
    output logic              ready,
    output logic              pend,
    output logic [ADDR_W-1:0] reg_sp,
    output logic [BYTE_W-1:0] reg_a,
    output logic [ADDR_W-1:0] reg_hx,
    output logic [BYTE_W-1:0] reg_ccr
);

    sq_e state_q;
    sq_e state_d;

    // Next-state logic: T_BOOT, T_HI_DONE, T_LO_DONE, T_ESCAPE, T_SECOND
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_RESET:  state_d = SQ_VEC_HI;
            SQ_VEC_HI: if (vec_ack) state_d = SQ_VEC_LO;
            SQ_VEC_LO: if (vec_ack) state_d = SQ_RUN;
            SQ_RUN:    if (byte_vld && is_esc) state_d = SQ_ESC;
            SQ_ESC:    if (byte_vld) state_d = SQ_RUN;
            default:   state_d = SQ_RESET;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_RESET;
        else        state_q <= state_d;
    end

    // Registered outputs: start address and reset register image
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pc <= '0;
            reg_sp   <= RESET_SP;
            reg_a    <= '0;
            reg_hx   <= '0;
            reg_ccr  <= RESET_CCR;
        end else begin
            if (state_q == SQ_VEC_HI && vec_ack)
                start_pc[ADDR_W-1:BYTE_W] <= vec_data;
            if (state_q == SQ_VEC_LO && vec_ack)
                start_pc[BYTE_W-1:0] <= vec_data;
        end
    end

    // State-decoded outputs
    assign vec_req  = (state_q == SQ_VEC_HI) || (state_q == SQ_VEC_LO);
    assign vec_addr = (state_q == SQ_VEC_LO) ? (VEC_BASE | 16'h0001) : VEC_BASE;
    assign ready    = (state_q == SQ_RUN) || (state_q == SQ_ESC);
    assign pend     = (state_q == SQ_ESC);

endmodule

// File: rtl/prefixed_op_decoder.sv
module prefixed_op_decoder
    import opdec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ESC_BYTE  = 8'h9E,
    parameter logic [ADDR_W-1:0] VEC_BASE  = 16'hFFFE,
    parameter logic [ADDR_W-1:0] RESET_SP  = 16'h00FF,
    parameter logic [BYTE_W-1:0] RESET_CCR = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              vec_ack,
    input  logic [BYTE_W-1:0] vec_data,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [ADDR_W-1:0] start_pc,
    output logic              ready,
    output logic              pfx_pend,
    output logic              op_vld,
    output logic [OP_W-1:0]   op_code,
    output logic              stk_rel,
    output logic              bad_op,
    output logic [ADDR_W-1:0] reg_sp,
    output logic [BYTE_W-1:0] reg_a,
    output logic [ADDR_W-1:0] reg_hx,
    output logic [BYTE_W-1:0] reg_ccr
);

    op_e  p_op;
    logic p_inv;
    logic p_esc;
    op_e  s_op;
    logic s_inv;
    logic accept;
    logic run_esc;
    op_e  op_q;

    opdec_primary #(.ESC_BYTE(ESC_BYTE)) u_pri (
        .code  (byte_in),
        .op    (p_op),
        .inval (p_inv),
        .esc   (p_esc)
    );

    opdec_stack u_stk (
        .code  (byte_in),
        .op    (s_op),
        .inval (s_inv)
    );

    opdec_seq #(
        .VEC_BASE (VEC_BASE),
        .RESET_SP (RESET_SP),
        .RESET_CCR(RESET_CCR)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .is_esc   (run_esc),
        .vec_ack  (vec_ack),
        .vec_data (vec_data),
        .vec_req  (vec_req),
        .vec_addr (vec_addr),
        .start_pc (start_pc),
        .ready    (ready),
        .pend     (pfx_pend),
        .reg_sp   (reg_sp),
        .reg_a    (reg_a),
        .reg_hx   (reg_hx),
        .reg_ccr  (reg_ccr)
    );

    assign accept  = ready && byte_vld;
    assign run_esc = p_esc && !pfx_pend;

    // Result register: one-cycle pulse per accepted non-escape byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            op_vld  <= 1'b0;
            bad_op  <= 1'b0;
            stk_rel <= 1'b0;
        end else begin
            op_q    <= OP_NONE;
            op_vld  <= 1'b0;
            bad_op  <= 1'b0;
            stk_rel <= 1'b0;
            if (accept) begin
                if (pfx_pend) begin
                    op_q    <= s_op;
                    op_vld  <= 1'b1;
                    bad_op  <= s_inv;
                    stk_rel <= !s_inv;
                end else if (!p_esc) begin
                    op_q    <= p_op;
                    op_vld  <= 1'b1;
                    bad_op  <= p_inv;
                end
            end
        end
    end

    assign op_code = op_q;

endmodule

// File: rtl/prefixed_op_decoder_chk.sv
module prefixed_op_decoder_chk
    import opdec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              byte_vld,
    input logic [BYTE_W-1:0] byte_in,
    input logic              vec_ack,
    input logic              vec_req,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              ready,
    input logic              pfx_pend,
    input logic              op_vld,
    input logic [OP_W-1:0]   op_code,
    input logic              stk_rel,
    input logic              bad_op
);

    AST_VEC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && vec_ack && vec_addr == 16'hFFFE) |=> (vec_req && vec_addr == 16'hFFFF)); // R2

    AST_NO_EARLY_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !op_vld); // R3

    AST_ESC_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && byte_vld && !pfx_pend && byte_in == 8'h9E) |=> (pfx_pend && !op_vld)); // R8

    AST_ESC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && byte_vld && pfx_pend) |=> (!pfx_pend && op_vld)); // R8

    AST_STK_AFTER_PFX: assert property (@(posedge clk) disable iff (!rst_n)
        stk_rel |-> $past(pfx_pend)); // R9

    AST_BAD_IS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> (op_vld && op_code == OP_NONE && !stk_rel)); // R10

    AST_VLD_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |-> $past(ready && byte_vld)); // R12

endmodule

bind prefixed_op_decoder prefixed_op_decoder_chk u_chk (.*);

// File: tb/sim_prefixed_op_decoder.sv
`timescale 1ns/1ps
module sim_prefixed_op_decoder;
    import opdec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        vec_ack = 1'b0;
    logic [7:0]  vec_data = 8'h00;
    logic        vec_req;
    logic [15:0] vec_addr;
    logic [15:0] start_pc;
    logic        ready;
    logic        pfx_pend;
    logic        op_vld;
    logic [5:0]  op_code;
    logic        stk_rel;
    logic        bad_op;
    logic [15:0] reg_sp;
    logic [7:0]  reg_a;
    logic [15:0] reg_hx;
    logic [7:0]  reg_ccr;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    prefixed_op_decoder u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .vec_ack(vec_ack), .vec_data(vec_data), .vec_req(vec_req),
        .vec_addr(vec_addr), .start_pc(start_pc), .ready(ready),
        .pfx_pend(pfx_pend), .op_vld(op_vld), .op_code(op_code),
        .stk_rel(stk_rel), .bad_op(bad_op), .reg_sp(reg_sp), .reg_a(reg_a),
        .reg_hx(reg_hx), .reg_ccr(reg_ccr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Offer one byte at a falling edge; returns at the falling edge after capture
    task automatic send(input logic [7:0] b);
        byte_vld = 1'b1;
        byte_in  = b;
        @(posedge clk);
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic boot(input logic [7:0] hi, input logic [7:0] lo);
        while (!vec_req) @(negedge clk);
        chk("R2", "first vec_addr", 32'(vec_addr), 32'hFFFE);
        chk("R2", "ready before vector", 32'(ready), 32'h0);
        vec_ack  = 1'b1;
        vec_data = hi;
        @(posedge clk);
        @(negedge clk);
        chk("R2", "second vec_req", 32'(vec_req), 32'h1);
        chk("R2", "second vec_addr", 32'(vec_addr), 32'hFFFF);
        vec_data = lo;
        @(posedge clk);
        @(negedge clk);
        vec_ack = 1'b0;
        chk("R2", "ready after vector", 32'(ready), 32'h1);
        chk("R2", "vec_req after vector", 32'(vec_req), 32'h0);
        chk("R2", "start_pc", 32'(start_pc), {16'h0, hi, lo});
    endtask

    // Independent reference of the primary table, written per full code
    function automatic op_e ref_pri(input logic [7:0] b);
        int r = b >> 4;
        int c = b & 15;
        op_e rmw [16] = '{OP_NEG, OP_CBEQ, OP_NONE, OP_COM, OP_LSR, OP_NONE, OP_ROR, OP_ASR,
                          OP_LSL, OP_ROL, OP_DEC, OP_DBNZ, OP_INC, OP_TST, OP_NONE, OP_CLR};
        op_e alu [16] = '{OP_SUB, OP_CMP, OP_SBC, OP_CPX, OP_AND, OP_BIT, OP_LDA, OP_STA,
                          OP_EOR, OP_ADC, OP_ORA, OP_ADD, OP_JMP, OP_JSR, OP_LDX, OP_STX};
        op_e r8 [16]  = '{OP_RTI, OP_RTS, OP_NONE, OP_SWI, OP_XFER, OP_XFER, OP_STKMOV, OP_STKMOV,
                          OP_STKMOV, OP_STKMOV, OP_STKMOV, OP_STKMOV, OP_CLRH, OP_NONE, OP_STOP, OP_WAIT};
        op_e r9 [16]  = '{OP_BCC, OP_BCC, OP_BCC, OP_BCC, OP_XFER, OP_XFER, OP_NONE, OP_XFER,
                          OP_FLAG, OP_FLAG, OP_FLAG, OP_FLAG, OP_RSP, OP_NOP, OP_NONE, OP_XFER};
        case (b)
            8'h42: return OP_MUL;
            8'h52: return OP_DIV;
            8'h62: return OP_NSA;
            8'h72: return OP_DAA;
            8'h35: return OP_STHX;
            8'h45, 8'h55: return OP_LDHX;
            8'h65, 8'h75: return OP_CPHX;
            8'h4E, 8'h5E, 8'h6E, 8'h7E: return OP_MOV;
            8'hA7: return OP_AIS;
            8'hAC: return OP_NONE;
            8'hAD: return OP_BSR;
            8'hAF: return OP_AIX;
            default: ;
        endcase
        if (r == 0) return OP_BITBR;
        if (r == 1) return OP_BITSC;
        if (r == 2) return OP_BCC;
        if (r <= 7) return rmw[c];
        if (r == 8) return r8[c];
        if (r == 9) return r9[c];
        return alu[c];
    endfunction

    function automatic op_e ref_stk(input logic [7:0] b);
        int r = b >> 4;
        int c = b & 15;
        if (r == 6) begin
            if (c == 2 || c == 5 || c == 14) return OP_NONE;
            return ref_pri(8'(8'h70 | c));
        end
        if (r == 13 || r == 14) begin
            if (c == 12) return OP_NONE;
            return ref_pri(8'(8'hB0 | c));
        end
        return OP_NONE;
    endfunction

    initial begin
        // R1: reset image while reset is held
        repeat (3) @(negedge clk);
        chk("R1", "reg_sp", 32'(reg_sp), 32'h00FF);
        chk("R1", "reg_a", 32'(reg_a), 32'h0);
        chk("R1", "reg_hx", 32'(reg_hx), 32'h0);
        chk("R1", "reg_ccr", 32'(reg_ccr), 32'h60);
        chk("R1", "flags", {28'h0, op_vld, bad_op, stk_rel, pfx_pend}, 32'h0);
        chk("R1", "ready", 32'(ready), 32'h0);
        rst_n = 1'b1;

        // R3: byte offered before the vector fetch is ignored
        send(8'h42);
        chk("R3", "op_vld before ready", 32'(op_vld), 32'h0);

        boot(8'hC3, 8'h5A);

        // R4 R5 R6 R7 R10: sweep of the primary table
        for (int b = 0; b < 256; b++) begin
            op_e e;
            if (b == 'h9E) continue;
            e = ref_pri(8'(b));
            send(8'(b));
            chk("R4-7", $sformatf("op 0x%02h", b), 32'(op_code), 32'(e));
            chk("R10", $sformatf("bad 0x%02h", b), 32'(bad_op), 32'(e == OP_NONE));
            chk("R12", $sformatf("vld 0x%02h", b), 32'(op_vld), 32'h1);
            chk("R9", $sformatf("stk 0x%02h", b), 32'(stk_rel), 32'h0);
        end

        // R8 R9: sweep of the escaped table
        for (int b = 0; b < 256; b++) begin
            op_e e;
            e = ref_stk(8'(b));
            send(8'h9E);
            chk("R8", "pend after escape", 32'(pfx_pend), 32'h1);
            chk("R8", "no result for escape", 32'(op_vld), 32'h0);
            send(8'(b));
            chk("R9", $sformatf("esc op 0x%02h", b), 32'(op_code), 32'(e));
            chk("R9", $sformatf("esc stk 0x%02h", b), 32'(stk_rel), 32'(e != OP_NONE));
            chk("R10", $sformatf("esc bad 0x%02h", b), 32'(bad_op), 32'(e == OP_NONE));
            chk("R8", "pend cleared", 32'(pfx_pend), 32'h0);
        end

        // R12: pulse lasts one cycle
        send(8'h9D);
        chk("R12", "nop valid", 32'(op_vld), 32'h1);
        @(negedge clk);
        chk("R12", "pulse ended", 32'(op_vld), 32'h0);
        // R10: invalid pulse ends too
        send(8'hAC);
        chk("R10", "bad pulse", 32'(bad_op), 32'h1);
        @(negedge clk);
        chk("R10", "bad pulse ended", 32'(bad_op), 32'h0);

        // R11: reset while prefix pending discards it
        send(8'h9E);
        chk("R11", "pend before reset", 32'(pfx_pend), 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "pend in reset", 32'(pfx_pend), 32'h0);
        rst_n = 1'b1;
        boot(8'h12, 8'h34);
        send(8'h42);
        chk("R11", "primary after reset", 32'(op_code), 32'(OP_MUL));
        chk("R11", "not stack-relative", 32'(stk_rel), 32'h0);

        finish_run();
    end

endmodule